// File: doc/BRIEF.md
# Pin I/O and Cycle-Wait CSR Unit

This unit sits beside a RISC-V core's CSR file and gives software direct control of a bank of general-purpose pins. Three pin registers are mapped into CSR space: an output latch, a per-pin direction mask, and a read-only view of the pin levels after resynchronisation. A pin drives its latch bit only while its direction bit is set. Otherwise the pin floats as an input.

A separate wait register gives the core deterministic timing. When the core writes a target count to it, the unit raises a stall toward the pipeline. The stall holds until the free-running cycle counter, which the unit receives as an input, equals that target exactly, with 32-bit wraparound. The counter value itself can also be read through a read-only CSR. The pipeline treats the stall as a freeze, so the unit ignores every CSR write that arrives while the stall is high.

Top module: `gpw_csr_unit`

## Requirements
- R1: While reset is asserted and after it is released, the direction and output latch registers are 0, pin_oe and pin_out are all 0, stall is low and the wait target reads 0.
- R2: pin_oe equals the direction register bit for bit. pin_out bit i equals output latch bit i when direction bit i is 1, and is 0 otherwise.
- R3: A write to address 0x7C0 loads the output latch at the next clock edge. Reading 0x7C0 returns the latch.
- R4: A write to address 0x7C1 loads the direction register at the next clock edge. Reading 0x7C1 returns it.
- R5: Reading address 0xFC0 returns pin_in as it was sampled two clock edges earlier, through a two-stage synchronizer.
- R6: Reading address 0xFC1 returns cycle_cnt in the same cycle. Writes to 0xFC0 and 0xFC1 change no register.
- R7: A write of target T to address 0x7C2 while stall is low raises stall after that edge. Stall stays high in every cycle up to and including the first cycle in which cycle_cnt equals T, and falls at the following edge.
- R8: Release requires exact equality. A target below the current count is reached only after the counter wraps, and a counter that jumps past the target keeps the stall high.
- R9: CSR writes presented while stall is high are ignored. This applies to the output latch, the direction register and the wait target.
- R10: Reading 0x7C2 returns the last accepted wait target. Reads of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| csr_addr | input | 12 | CSR address for the read and the write |
| csr_wdata | input | 32 | CSR write data |
| csr_we | input | 1 | CSR write enable |
| csr_rdata | output | 32 | CSR read data, combinational from csr_addr |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Pin drive values, gated by direction |
| pin_oe | output | 32 | Per-pin output enable |
| cycle_cnt | input | 32 | Free-running cycle counter |
| stall | output | 1 | Freeze request to the core pipeline |

## Verification
The bench uses the default parameters: 32 pins, 32-bit data and counter, and a two-stage synchronizer. Because the bench drives the counter input itself, it can place the count just below the 32-bit limit, so a wait that crosses wraparound takes only about twenty cycles. For the same reason, the bench can make the counter jump over a target to show that only exact equality releases the stall. A behavioural model tracks the registers, the synchronizer history and the wait state. The model is compared with every output on every cycle, under directed waits and a randomized mix of reads, writes and short waits.

// File: rtl/gpw_pkg.sv
package gpw_pkg;
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_OUT  = 3'd1,
    SEL_DIR  = 3'd2,
    SEL_WAIT = 3'd3,
    SEL_IN   = 3'd4,
    SEL_CNT  = 3'd5
  } gpw_sel_e;
endpackage

// File: rtl/gpw_sync.sv
module gpw_sync #(
  parameter int PIN_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] async_i,
  output logic [PIN_W-1:0] sync_o
);
  logic [PIN_W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [PIN_W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = async_i;
      end else begin : g_rest
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpw_pinregs.sv
module gpw_pinregs #(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             wr_out_i,
  input  logic             wr_dir_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] out_q,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe
);
  logic [PIN_W-1:0] out_d, dir_d;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (wr_out_i) out_d = wdata_i;
    if (wr_dir_i) dir_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_out_i) out_q <= out_d;
      if (wr_dir_i) dir_q <= dir_d;
    end
  end

  generate
    for (genvar i = 0; i < PIN_W; i++) begin : g_pad
      assign pin_oe[i]  = dir_q[i];
      assign pin_out[i] = dir_q[i] & out_q[i];
    end
  endgenerate

  // R2: a pin that is not enabled never shows a driven 1
  p_undriven_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  // R9: a frozen core cannot alter the pin registers
  p_frozen_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpw_waitctl.sv
module gpw_waitctl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] tgt_q
);
  logic             wait_q, wait_d;
  logic [CNT_W-1:0] tgt_d;
  logic             tgt_en;
  logic             hit;

  assign hit    = (cnt_i == tgt_q);
  assign tgt_en = wr_i & ~wait_q;

  always_comb begin
    wait_d = wait_q;
    tgt_d  = tgt_q;
    if (wait_q) begin
      if (hit) wait_d = 1'b0;
    end else if (wr_i) begin
      wait_d = 1'b1;
      tgt_d  = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      if (tgt_en) tgt_q <= tgt_d;
    end
  end

  assign stall_o = wait_q;

  // R7: accepted write arms the stall with the written target
  p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_q && wr_i) |=> (wait_q && tgt_q == $past(wdata_i)));

  // R7: no release before the match
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && cnt_i != tgt_q) |=> wait_q);

  // R8: exact equality releases at the next edge
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && cnt_i == tgt_q) |=> !wait_q);

  // R9: target is frozen during a wait
  p_tgt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |=> $stable(tgt_q));
endmodule

// File: rtl/gpw_csr_unit.sv
module gpw_csr_unit #(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          PIN_W     = 32,
  parameter int          CNT_W     = 32,
  parameter int          SYNC_STG  = 2,
  parameter logic [11:0] ADDR_OUT  = 12'h7C0,
  parameter logic [11:0] ADDR_DIR  = 12'h7C1,
  parameter logic [11:0] ADDR_WAIT = 12'h7C2,
  parameter logic [11:0] ADDR_IN   = 12'hFC0,
  parameter logic [11:0] ADDR_CNT  = 12'hFC1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              csr_we,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  input  logic [CNT_W-1:0]  cycle_cnt,
  output logic              stall
);
  import gpw_pkg::*;

  gpw_sel_e         sel;
  logic             wr_ok;
  logic [PIN_W-1:0] in_sync, out_q, dir_q;
  logic [CNT_W-1:0] tgt_q;

  always_comb begin
    sel = SEL_NONE;
    if      (csr_addr == ADDR_W'(ADDR_OUT))  sel = SEL_OUT;
    else if (csr_addr == ADDR_W'(ADDR_DIR))  sel = SEL_DIR;
    else if (csr_addr == ADDR_W'(ADDR_WAIT)) sel = SEL_WAIT;
    else if (csr_addr == ADDR_W'(ADDR_IN))   sel = SEL_IN;
    else if (csr_addr == ADDR_W'(ADDR_CNT))  sel = SEL_CNT;
  end

  assign wr_ok = csr_we & ~stall;

  gpw_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (in_sync)
  );

  gpw_pinregs #(.PIN_W(PIN_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_i  (stall),
    .wr_out_i (wr_ok && sel == SEL_OUT),
    .wr_dir_i (wr_ok && sel == SEL_DIR),
    .wdata_i  (csr_wdata[PIN_W-1:0]),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  gpw_waitctl #(.CNT_W(CNT_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_ok && sel == SEL_WAIT),
    .wdata_i (csr_wdata[CNT_W-1:0]),
    .cnt_i   (cycle_cnt),
    .stall_o (stall),
    .tgt_q   (tgt_q)
  );

  always_comb begin
    unique case (sel)
      SEL_OUT:  csr_rdata = DATA_W'(out_q);
      SEL_DIR:  csr_rdata = DATA_W'(dir_q);
      SEL_WAIT: csr_rdata = DATA_W'(tgt_q);
      SEL_IN:   csr_rdata = DATA_W'(in_sync);
      SEL_CNT:  csr_rdata = DATA_W'(cycle_cnt);
      default:  csr_rdata = '0;
    endcase
  end

  // R6: writes to read-only addresses leave the pin registers alone
  p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (sel == SEL_IN || sel == SEL_CNT)) |=>
      ($stable(pin_out) && $stable(pin_oe)));

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (csr_rdata == '0));
endmodule

// File: tb/gpw_csr_unit_tb.sv
module gpw_csr_unit_tb;
  localparam logic [11:0] A_OUT  = 12'h7C0;
  localparam logic [11:0] A_DIR  = 12'h7C1;
  localparam logic [11:0] A_WAIT = 12'h7C2;
  localparam logic [11:0] A_IN   = 12'hFC0;
  localparam logic [11:0] A_CNT  = 12'hFC1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [31:0] cnt_r = '0;
  logic        stall;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpw_csr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(csr_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .cycle_cnt(cnt_r), .stall(stall)
  );

  // behavioural reference model
  logic [31:0] m_out, m_dir, m_tgt;
  bit          m_wait;
  logic [31:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_tgt = '0; m_wait = 1'b0;
      hist = {32'h0, 32'h0};
    end else begin
      hist.push_front(pin_in);
      if (hist.size() > 2) void'(hist.pop_back());
      if (m_wait) begin
        if (cnt_r == m_tgt) m_wait = 1'b0;
      end else if (csr_we) begin
        if (csr_addr == A_OUT) m_out = csr_wdata;
        else if (csr_addr == A_DIR) m_dir = csr_wdata;
        else if (csr_addr == A_WAIT) begin
          m_tgt = csr_wdata; m_wait = 1'b1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] er;
    string tag;
    case (csr_addr)
      A_OUT:  begin er = m_out;   tag = "R3 rdata"; end
      A_DIR:  begin er = m_dir;   tag = "R4 rdata"; end
      A_WAIT: begin er = m_tgt;   tag = "R10 rdata"; end
      A_IN:   begin er = hist[1]; tag = "R5 rdata"; end
      A_CNT:  begin er = cnt_r;   tag = "R6 rdata"; end
      default: begin er = '0;     tag = "R10 rdata"; end
    endcase
    chk(tag, csr_rdata, er);
    chk("R7 stall", {31'b0, stall}, {31'b0, m_wait});
    chk("R2 pin_oe", pin_oe, m_dir);
    chk("R2 pin_out", pin_out, m_out & m_dir);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    cnt_r = cnt_r + 1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    step();
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    step();
    csr_we = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall) begin
      n++;
      step();
    end
  endtask

  initial begin
    int n;
    repeat (3) begin
      pin_in = 32'hDEAD_BEEF;
      step();
    end
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 stall", {31'b0, stall}, 32'h0);
    rst_n = 1'b1;
    csr_addr = A_WAIT;
    step();
    chk("R1 target", csr_rdata, 32'h0);
    csr_addr = A_OUT;
    step();
    chk("R1 out", csr_rdata, 32'h0);

    // R3 R4 R2
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_OUT, 32'hA5A5_A5A5);
    csr_addr = A_OUT; step();
    chk("R3 readback", csr_rdata, 32'hA5A5_A5A5);
    chk("R2 gated", pin_out, 32'h0000_A5A5);
    csr_addr = A_DIR; step();
    chk("R4 readback", csr_rdata, 32'h0000_FFFF);

    // R5 two-edge synchronizer delay
    pin_in = 32'h1234_5678; csr_addr = A_IN;
    step();
    chk("R5 one edge", csr_rdata, 32'hDEAD_BEEF);
    step();
    chk("R5 two edges", csr_rdata, 32'h1234_5678);

    // R6 counter read, writes to read-only addresses
    csr_addr = A_CNT; cnt_r = 32'h0BAD_F00D;
    step();
    chk("R6 cnt", csr_rdata, 32'h0BAD_F00E - 32'h1);
    wr(A_IN, 32'hFFFF_FFFF);
    wr(A_CNT, 32'hFFFF_FFFF);
    csr_addr = A_OUT; step();
    chk("R6 ro write", csr_rdata, 32'hA5A5_A5A5);

    // R7 basic wait, R9 writes during stall
    step();
    csr_we = 1'b1; csr_addr = A_WAIT; csr_wdata = cnt_r + 5;
    step();
    csr_we = 1'b1; csr_addr = A_OUT; csr_wdata = 32'h0F0F_0F0F;
    count_stall(n);
    csr_we = 1'b0;
    chk("R7 stall cycles", n, 5);
    csr_addr = A_OUT; step();
    chk("R9 out unchanged", csr_rdata, 32'hA5A5_A5A5);

    // R8 wraparound
    step();
    cnt_r = 32'hFFFF_FFF0;
    csr_we = 1'b1; csr_addr = A_WAIT; csr_wdata = 32'h4;
    step();
    csr_we = 1'b0;
    count_stall(n);
    chk("R8 wrap cycles", n, 20);

    // R8 passing the target, R9 wait write during stall
    step();
    cnt_r = 32'd100;
    csr_we = 1'b1; csr_addr = A_WAIT; csr_wdata = 32'd50;
    step();
    csr_wdata = 32'd300;
    cnt_r = 32'd200;
    repeat (5) step();
    csr_we = 1'b0;
    chk("R8 passed target", {31'b0, stall}, 32'h1);
    csr_addr = A_WAIT; step();
    chk("R9 target kept", csr_rdata, 32'd50);
    cnt_r = 32'd47;
    count_stall(n);
    chk("R8 exact release", n, 4);

    // R7 target one ahead
    step();
    csr_we = 1'b1; csr_addr = A_WAIT; csr_wdata = cnt_r + 1;
    step();
    csr_we = 1'b0;
    count_stall(n);
    chk("R7 minimal wait", n, 1);

    // R10 unmapped
    csr_addr = 12'h123; step();
    chk("R10 unmapped", csr_rdata, 32'h0);

    // randomized mix
    for (int i = 0; i < 400; i++) begin
      int k;
      step();
      k = $urandom % 7;
      case (k)
        0: csr_addr = A_OUT;
        1: csr_addr = A_DIR;
        2: csr_addr = A_WAIT;
        3: csr_addr = A_IN;
        4: csr_addr = A_CNT;
        default: csr_addr = 12'($urandom);
      endcase
      csr_we = ($urandom % 3) == 0;
      csr_wdata = $urandom;
      if (csr_addr == A_WAIT) csr_wdata = cnt_r + 1 + ($urandom % 6);
      pin_in = $urandom;
    end
    csr_we = 1'b0;
    repeat (10) step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule